// File: doc/BRIEF.md
# Optical link supervisor

This controller decides whether a fibre link is up or down and gates the transmit, receive and loopback paths to match. It has three status inputs. One is a power-good flag that an upstream comparator has already sliced. The other two show whether the transmit path is idle and whether receive data is present. All three are asynchronous to the controller, so each one passes through a two-flop synchroniser before the state machine sees it.

After reset, and whenever received power has been lost, the link is in low-light. In this state all three path enables are deasserted and the active-low LED output is high, so the LED is dark. Power-good must hold for a qualify window of `QUAL_CYC` cycles. The controller then waits a settling interval of `SETTLE_CYC` cycles. After that it needs one cycle in which the transmit side is idle and no receive data is present, and only then does it bring the link up. To take a live link back down, power-good must stay low for twice the qualify window.

A square wave at `IDLE_HZ`, divided from `CLK_HZ`, drives the transmitter's idle signalling. It runs in every state, low-light included. All pins are plain level signals, with no handshake.

Top module: `fiber_link_supervisor`

## Requirements
- R1: While `rst_n` is low, `tx_en_o`, `rx_en_o` and `lpbk_en_o` are 0, `link_led_n_o` is 1 and `idle_wave_o` is 0.
- R2: In every state other than link-up, all three enables are 0 and `link_led_n_o` is 1. In link-up, all three enables are 1 and `link_led_n_o` is 0.
- R3: Leaving low-light needs `QUAL_CYC` consecutive synchronised cycles of power-good high. A single low cycle restarts the count from zero.
- R4: A link that is up goes down only after 2·`QUAL_CYC` consecutive synchronised cycles of power-good low. A shorter dip leaves the link up.
- R5: Once power-good is qualified, the controller waits exactly `SETTLE_CYC` cycles before it tests the quiet condition. With quiet inputs, the enables rise `QUAL_CYC`+`SETTLE_CYC`+3 clock edges after power-good rises at the pin.
- R6: After settling, the link comes up only in a cycle where synchronised transmit-idle is 1 and synchronised receive-busy is 0. Otherwise the controller keeps waiting.
- R7: If power-good goes low during the settling wait or the quiet wait, the controller returns to low-light and clears its timers. A later rise then needs the full R5 latency again.
- R8: `idle_wave_o` toggles every `CLK_HZ`/(2·`IDLE_HZ`) cycles in every state.
- R9: Each status input reaches the state machine through exactly two flops. When transmit-idle rises at the pin while the controller is waiting for quiet, the enables rise 3 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Received optical power above threshold (asynchronous) |
| tx_idle_i | input | 1 | Transmit path is idle (asynchronous) |
| rx_busy_i | input | 1 | Receive data is present (asynchronous) |
| tx_en_o | output | 1 | Transmit data path enable |
| rx_en_o | output | 1 | Receiver enable |
| lpbk_en_o | output | 1 | Loopback path enable |
| link_led_n_o | output | 1 | Link LED drive, active low |
| idle_wave_o | output | 1 | Idle square wave for the transmitter |

## Verification
The bench sweeps the length of a power-good pulse over every value from 1 cycle to beyond the full bring-up latency. A controller with an off-by-one in the qualify or settle counters would come up one pulse length too early or too late. It also sweeps dips in a live link across the 2·`QUAL_CYC` boundary. A controller that used the turn-on window for turn-off would drop the link on a dip that should be tolerated. Further tests drop power during settling and during the quiet wait, then time a fresh rise to make sure no stale timer carries over. Holding transmit-idle low, or receive-busy high, checks that the link stays down and then rises exactly 3 edges after the condition clears. The idle wave period is checked throughout, including while the link is down.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    LM_DOWN   = 2'd0,
    LM_SETTLE = 2'd1,
    LM_QUIET  = 2'd2,
    LM_UP     = 2'd3
  } lm_state_e;
endpackage

// File: rtl/lm_sync2.sv
module lm_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R9
  two_stage_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/lm_idle_wave.sv
module lm_idle_wave #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int IDLE_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave_o
);
  localparam int HALF = (CLK_HZ / (2 * IDLE_HZ) < 1) ? 1 : CLK_HZ / (2 * IDLE_HZ);
  localparam int CW   = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      wave_q <= ~wave_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wave_o = wave_q;

  // R8
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(wave_o));
  // R8
  wave_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (wave_o != $past(wave_o)));
endmodule

// File: rtl/lm_run_timer.sv
module lm_run_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = inc_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (done_o)     cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + 1'b1;
  end

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/fiber_link_supervisor.sv
module fiber_link_supervisor
  import lm_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int IDLE_HZ    = 1_000_000,
  parameter int QUAL_CYC   = 7_000_000,
  parameter int SETTLE_CYC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic tx_idle_i,
  input  logic rx_busy_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic lpbk_en_o,
  output logic link_led_n_o,
  output logic idle_wave_o
);
  localparam int DROP_CYC = 2 * QUAL_CYC;

  logic [2:0] raw_in, sync_in;
  logic pg_s, tx_idle_s, rx_busy_s;

  assign raw_in = {rx_busy_i, tx_idle_i, pwr_ok_i};

  lm_sync2 #(.W(3), .RST_VAL(3'b000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign pg_s      = sync_in[0];
  assign tx_idle_s = sync_in[1];
  assign rx_busy_s = sync_in[2];

  lm_state_e state_q, state_d;

  logic rise_inc, rise_done;
  logic drop_inc, drop_done;
  logic sett_inc, sett_done;

  assign rise_inc = (state_q == LM_DOWN)   && pg_s;
  assign drop_inc = (state_q == LM_UP)     && !pg_s;
  assign sett_inc = (state_q == LM_SETTLE) && pg_s;

  lm_run_timer #(.LIMIT(QUAL_CYC)) u_rise (
    .clk(clk), .rst_n(rst_n), .clr_i(!rise_inc), .inc_i(rise_inc), .done_o(rise_done)
  );
  lm_run_timer #(.LIMIT(DROP_CYC)) u_drop (
    .clk(clk), .rst_n(rst_n), .clr_i(!drop_inc), .inc_i(drop_inc), .done_o(drop_done)
  );
  lm_run_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr_i(!sett_inc), .inc_i(sett_inc), .done_o(sett_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LM_DOWN:   if (rise_done) state_d = LM_SETTLE;
      LM_SETTLE: begin
        if (!pg_s)          state_d = LM_DOWN;
        else if (sett_done) state_d = LM_QUIET;
      end
      LM_QUIET: begin
        if (!pg_s)                        state_d = LM_DOWN;
        else if (tx_idle_s && !rx_busy_s) state_d = LM_UP;
      end
      LM_UP:     if (drop_done) state_d = LM_DOWN;
      default:   state_d = LM_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LM_DOWN;
    else        state_q <= state_d;
  end

  logic link_up;
  assign link_up      = (state_q == LM_UP);
  assign tx_en_o      = link_up;
  assign rx_en_o      = link_up;
  assign lpbk_en_o    = link_up;
  assign link_led_n_o = !link_up;

  lm_idle_wave #(.CLK_HZ(CLK_HZ), .IDLE_HZ(IDLE_HZ)) u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .wave_o (idle_wave_o)
  );

  // R6
  quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> ($past(tx_idle_s) && !$past(rx_busy_s)));
  // R5
  settle_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> ($past(state_q) == LM_QUIET));
  // R7
  abort_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LM_SETTLE || state_q == LM_QUIET) && !pg_s) |=> (state_q == LM_DOWN));
  // R4
  hold_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && pg_s) |=> tx_en_o);
  // R4
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> !$past(pg_s));
endmodule

// File: tb/fiber_link_supervisor_tb_top.sv
module fiber_link_supervisor_tb_top;
  localparam int CLK_HZ = 16;
  localparam int IDLE_HZ = 1;
  localparam int Q = 4;
  localparam int S = 10;
  localparam int HALF = CLK_HZ / (2 * IDLE_HZ);
  localparam int N_UP = Q + S + 3;
  localparam int N_DN = 2 * Q + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, txi = 1'b1, rxb = 1'b0;
  logic tx_en, rx_en, lpbk_en, led_n, wave;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  bit ever_up, ever_dn;
  int gap = 0, toggles = 0, toggles_dn = 0;
  logic prev_wave = 1'b0;

  always #2.5 clk = ~clk;

  fiber_link_supervisor #(
    .CLK_HZ(CLK_HZ), .IDLE_HZ(IDLE_HZ), .QUAL_CYC(Q), .SETTLE_CYC(S)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pg), .tx_idle_i(txi), .rx_busy_i(rxb),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .lpbk_en_o(lpbk_en),
    .link_led_n_o(led_n), .idle_wave_o(wave)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8: idle wave period watched in every state
  always @(negedge clk) begin
    if (rst_n) begin
      gap++;
      if (tx_en) ever_up = 1'b1;
      else       ever_dn = 1'b1;
      if (wave != prev_wave) begin
        if (toggles > 0) chk("R8 half period", gap, HALF);
        toggles++;
        if (!tx_en) toggles_dn++;
        gap = 0;
      end
      prev_wave = wave;
    end
  end

  task automatic chk_up(input string tag, input bit exp);
    chk(tag, tx_en, exp);
    chk({tag, " rx"}, rx_en, exp);
    chk({tag, " lpbk"}, lpbk_en, exp);
    chk({tag, " led"}, led_n, !exp);
  endtask

  initial begin
    cyc(3);
    // R1
    chk_up("R1 reset", 1'b0);
    chk("R1 wave", wave, 0);
    rst_n = 1'b1;
    cyc(2);

    // R5, R2: full bring-up latency
    pg = 1'b1;
    cyc(N_UP - 1);
    chk_up("R5 early", 1'b0);
    cyc(1);
    chk_up("R5 R2 up", 1'b1);

    // R4: drop latency
    pg = 1'b0;
    cyc(N_DN - 1);
    chk("R4 still up", tx_en, 1);
    cyc(1);
    chk_up("R4 R2 down", 1'b0);

    // R3 R5 R7: pulse length sweep
    for (int len = 1; len <= N_UP + 2; len++) begin
      ever_up = 1'b0;
      pg = 1'b1;
      cyc(len);
      pg = 1'b0;
      cyc(2 * Q + 6);
      chk("R3 R7 pulse sweep", ever_up, (len >= Q + S + 1) ? 1 : 0);
      chk("R4 back down", tx_en, 0);
    end

    // R3: single-cycle dropouts restart qualification
    ever_up = 1'b0;
    for (int k = 0; k < 5; k++) begin
      pg = 1'b1; cyc(Q - 1);
      pg = 1'b0; cyc(1);
    end
    cyc(4);
    chk("R3 restart", ever_up, 0);
    pg = 1'b1;
    cyc(N_UP - 1);
    chk("R3 fresh early", tx_en, 0);
    cyc(1);
    chk("R3 fresh up", tx_en, 1);

    // R4: dip sweep on a live link
    for (int len = 1; len <= 2 * Q + 2; len++) begin
      ever_dn = 1'b0;
      pg = 1'b0;
      cyc(len);
      pg = 1'b1;
      cyc(4);
      chk("R4 dip sweep", ever_dn, (len >= 2 * Q) ? 1 : 0);
      cyc(N_UP + 2);
      chk("R4 recovered", tx_en, 1);
    end

    // R7: drop during settle
    pg = 1'b0; cyc(N_DN + 2);
    pg = 1'b1; cyc(Q + 6);
    pg = 1'b0; cyc(1);
    pg = 1'b1;
    cyc(N_UP - 1);
    chk("R7 settle abort early", tx_en, 0);
    cyc(1);
    chk("R7 settle abort up", tx_en, 1);

    // R6 R7: drop during quiet wait
    pg = 1'b0; cyc(N_DN + 2);
    txi = 1'b0;
    pg = 1'b1; cyc(N_UP + 4);
    chk("R6 held by tx busy", tx_en, 0);
    pg = 1'b0; txi = 1'b1; cyc(1);
    pg = 1'b1;
    cyc(N_UP - 1);
    chk("R7 quiet abort early", tx_en, 0);
    cyc(1);
    chk("R7 quiet abort up", tx_en, 1);

    // R6 R9: transmit-idle gate and its latency
    pg = 1'b0; cyc(N_DN + 2);
    txi = 1'b0;
    pg = 1'b1; cyc(N_UP + 6);
    chk_up("R6 tx not idle", 1'b0);
    txi = 1'b1;
    cyc(2);
    chk("R9 tx latency early", tx_en, 0);
    cyc(1);
    chk("R9 tx latency", tx_en, 1);

    // R6 R9: receive-activity gate
    pg = 1'b0; cyc(N_DN + 2);
    rxb = 1'b1;
    pg = 1'b1; cyc(N_UP + 6);
    chk_up("R6 rx busy", 1'b0);
    rxb = 1'b0;
    cyc(2);
    chk("R9 rx latency early", tx_en, 0);
    cyc(1);
    chk("R9 rx latency", tx_en, 1);

    // R8: wave kept running while link was down
    chk("R8 toggles in low-light", (toggles_dn > 10) ? 1 : 0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule